// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block handles the address-bit scrambling that a dual-channel memory controller applies to tiled surfaces. It interleaves the two channels at 64-byte granularity. For a tiled access, the channel-select bit (bit 6) is XORed with a set of higher address bits. The choice of bits depends on two things: whether the surface is tiled by rows (X) or by columns (Y), and whether the memory controller XORs in a high address bit of its own to spread strided traffic. The block decodes the active swizzle class from the memory-controller configuration and applies the matching transform to tile addresses combinationally. When the configuration cannot be trusted, it reports that pages must stay pinned.

The second function repairs a page whose physical bit 17 has changed since its contents were written. The page arrives as a stream of 64-byte beats. When the saved bit 17 and the current bit 17 disagree, the two 64-byte halves of every 128-byte chunk are exchanged. Otherwise the page streams through in order. Both cases have the same latency.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: On `out_addr`, every bit except bit 6 equals the same bit of `in_addr`. When `in_tiled` is 0 or the class is none (0), bit 6 is also unchanged.
- R2: With class base (1) and a tiled access, bit 6 is XORed with bits 9 and 10 when `in_tile_y` is 0 (X), and with bit 9 only when `in_tile_y` is 1 (Y).
- R3: With class bit-11 (2), the R2 result is also XORed with address bit 11.
- R4: With class bit-17 (3), the R2 result is also XORed with address bit 17.
- R5: With `cfg_from_dimm`=0, the class comes from `cfg_word`. Bits [1:0] hold the channel mode (0 single, 1 asymmetric dual, 2 interleaved dual). Bit 2 disables the controller XOR, and bit 3 selects bit 17 over bit 11. Modes 0 and 1 give class none. Mode 2 gives base when bit 2 is set, and otherwise bit-17 or bit-11 according to bit 3.
- R6: With `cfg_from_dimm`=0, the configuration is unknown when any one of these holds: `cfg_word` is all ones, `cfg_remap_en` is 1, or the channel mode is 3. An unknown configuration drives `pin_pages`=1 and class none. In every other case `pin_pages` is 0.
- R7: With `cfg_from_dimm`=1, the class is base when `dimm_a_size` equals `dimm_b_size` and none otherwise, and `pin_pages` is 0.
- R8: A page is 64 beats. The swap decision is `s_b17_saved` XOR `s_b17_now`, sampled on the page's first accepted beat. When it is 1, output order is beat 1, 0, 3, 2, …
- R9: When the sampled decision is 0, beats leave in input order.
- R10: Output timing is the same for both orders. The first beat of a pair is valid in the cycle after the pair's odd beat is accepted, and the second beat in the cycle after that. `m_last` is high only with the page's final output beat.
- R11: After reset, `m_valid` and `m_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | CFG_W | Raw memory-controller configuration word |
| cfg_remap_en | input | 1 | Modified (uneven) addressing layout is enabled |
| cfg_from_dimm | input | 1 | Derive class from DIMM size comparison |
| dimm_a_size | input | DIMM_W | Channel A populated size |
| dimm_b_size | input | DIMM_W | Channel B populated size |
| swz_class | output | 2 | Decoded class: 0 none, 1 base, 2 bit-11, 3 bit-17 |
| pin_pages | output | 1 | Configuration unknown, keep pages resident |
| in_addr | input | ADDR_W | Address to transform |
| in_tiled | input | 1 | Access targets a tiled surface |
| in_tile_y | input | 1 | 1 for Y tiling, 0 for X tiling |
| out_addr | output | ADDR_W | Swizzled address |
| s_valid | input | 1 | Input beat valid |
| s_data | input | BEAT_W | Input 64-byte beat |
| s_b17_saved | input | 1 | Bit 17 recorded when the page was written |
| s_b17_now | input | 1 | Current physical bit 17 of the page |
| m_valid | output | 1 | Output beat valid |
| m_data | output | BEAT_W | Output beat |
| m_last | output | 1 | Final beat of the page |

## Verification
The stream checks assume that beats of a page arrive with no more than one beat per cycle, and that an odd beat never lands in the cycle right after another odd beat. The pair logic depends on this, because a pending second half must drain before the next pair completes. The bench holds to it by sending beats back to back or with random idle gaps, always in page order. The flip inputs are randomised after beat 0 so that any sampling outside the first beat shows up. Address and configuration checks vary every input on each vector, and include directed all-ones words and remap cases.

// File: rtl/swz_pkg.sv
// Shared types for the bit-6 swizzle unit.
package swz_pkg;
    // Swizzle class: which extra bits join bit 6.
    typedef enum logic [1:0] {
        SWZ_NONE = 2'd0,
        SWZ_BASE = 2'd1,
        SWZ_B11  = 2'd2,
        SWZ_B17  = 2'd3
    } swz_class_e;

    // Channel addressing modes in cfg_word[1:0].
    localparam logic [1:0] CHM_SINGLE = 2'd0;
    localparam logic [1:0] CHM_ASYM   = 2'd1;
    localparam logic [1:0] CHM_ILV    = 2'd2;
endpackage

// File: rtl/swz_mode_decode.sv
// Derives the swizzle class from memory-controller configuration.
// Assumes cfg_word fields: [1:0] channel mode, [2] XOR disable, [3] bit-17 select.
// Purely combinational.
module swz_mode_decode
    import swz_pkg::*;
#(
    parameter int CFG_W  = 32,
    parameter int DIMM_W = 8
) (
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_remap_en,
    input  logic              cfg_from_dimm,
    input  logic [DIMM_W-1:0] dimm_a_size,
    input  logic [DIMM_W-1:0] dimm_b_size,
    output swz_class_e        cls,
    output logic              pin
);
    logic [1:0] chm;
    logic       unknown;
    swz_class_e reg_cls;

    assign chm = cfg_word[1:0];

    // Untrusted configuration detection.
    always_comb begin
        unknown = (&cfg_word) || cfg_remap_en || (chm == 2'd3);
    end

    // Class from channel mode and XOR controls.
    always_comb begin
        reg_cls = SWZ_NONE;
        if (chm == CHM_ILV) begin
            if (cfg_word[2])      reg_cls = SWZ_BASE;
            else if (cfg_word[3]) reg_cls = SWZ_B17;
            else                  reg_cls = SWZ_B11;
        end
    end

    // Select decode source and fold unknown into none.
    always_comb begin
        if (cfg_from_dimm) begin
            cls = (dimm_a_size == dimm_b_size) ? SWZ_BASE : SWZ_NONE;
            pin = 1'b0;
        end else if (unknown) begin
            cls = SWZ_NONE;
            pin = 1'b1;
        end else begin
            cls = reg_cls;
            pin = 1'b0;
        end
    end
endmodule

// File: rtl/swz_addr_xform.sv
// Applies the bit-6 XOR to a tiled address for the given class.
// Assumes ADDR_W >= 18 so bit 17 exists. Purely combinational.
module swz_addr_xform
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_tiled,
    input  logic              in_tile_y,
    input  swz_class_e        cls,
    output logic [ADDR_W-1:0] out_addr
);
    logic flip;

    // Compute the XOR term for bit 6.
    always_comb begin
        flip = 1'b0;
        if (in_tiled && cls != SWZ_NONE) begin
            flip = in_addr[9] ^ (in_tile_y ? 1'b0 : in_addr[10]);
            if (cls == SWZ_B11) flip = flip ^ in_addr[11];
            if (cls == SWZ_B17) flip = flip ^ in_addr[17];
        end
    end

    // Replace bit 6 only.
    always_comb begin
        out_addr    = in_addr;
        out_addr[6] = in_addr[6] ^ flip;
    end
endmodule

// File: rtl/swz_page_swap.sv
// Streams a page of beats, exchanging each even/odd pair when the page's
// bit 17 changed. Assumes beats of a page arrive in order, at most one per
// cycle, and never two odd beats on consecutive cycles.
module swz_page_swap #(
    parameter int BEAT_W     = 512,
    parameter int PAGE_BEATS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [BEAT_W-1:0] s_data,
    input  logic              s_flip,
    output logic              m_valid,
    output logic [BEAT_W-1:0] m_data,
    output logic              m_last
);
    localparam int CNT_W = $clog2(PAGE_BEATS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAGE_BEATS - 1);

    logic [CNT_W-1:0]  cnt;
    logic              swap_q;
    logic [BEAT_W-1:0] hold;
    logic [BEAT_W-1:0] pend_data;
    logic              pend;
    logic              pend_last;
    logic              odd_in;

    assign odd_in = s_valid && cnt[0];

    // Beat counter, swap decision and output pair sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            swap_q    <= 1'b0;
            pend      <= 1'b0;
            pend_last <= 1'b0;
            m_valid   <= 1'b0;
            m_last    <= 1'b0;
        end else begin
            m_valid <= 1'b0;
            m_last  <= 1'b0;
            if (pend) begin
                m_valid <= 1'b1;
                m_data  <= pend_data;
                m_last  <= pend_last;
                pend    <= 1'b0;
            end
            if (s_valid) begin
                if (cnt == '0) swap_q <= s_flip;
                if (!cnt[0]) begin
                    hold <= s_data;
                end else begin
                    m_valid   <= 1'b1;
                    m_data    <= swap_q ? s_data : hold;
                    pend_data <= swap_q ? hold : s_data;
                    pend      <= 1'b1;
                    pend_last <= (cnt == LAST_IDX);
                end
                cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
            end
        end
    end

    AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !pend) else $error("pending beat held"); // R10
    AST_PAIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        odd_in |=> m_valid) else $error("pair head missing"); // R10
    AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        odd_in |=> ##1 m_valid) else $error("pair tail missing"); // R10
    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid) else $error("last without valid"); // R10
endmodule

// File: rtl/bit6_swizzle_unit.sv
// Top: class decode, address transform and page half-swap stream.
// Assumes ADDR_W >= 18 and PAGE_BEATS a power of two.
module bit6_swizzle_unit
    import swz_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CFG_W      = 32,
    parameter int DIMM_W     = 8,
    parameter int BEAT_W     = 512,
    parameter int PAGE_BEATS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_remap_en,
    input  logic              cfg_from_dimm,
    input  logic [DIMM_W-1:0] dimm_a_size,
    input  logic [DIMM_W-1:0] dimm_b_size,
    output logic [1:0]        swz_class,
    output logic              pin_pages,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_tiled,
    input  logic              in_tile_y,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              s_valid,
    input  logic [BEAT_W-1:0] s_data,
    input  logic              s_b17_saved,
    input  logic              s_b17_now,
    output logic              m_valid,
    output logic [BEAT_W-1:0] m_data,
    output logic              m_last
);
    swz_class_e cls;

    swz_mode_decode #(.CFG_W(CFG_W), .DIMM_W(DIMM_W)) u_dec (
        .cfg_word(cfg_word), .cfg_remap_en(cfg_remap_en),
        .cfg_from_dimm(cfg_from_dimm), .dimm_a_size(dimm_a_size),
        .dimm_b_size(dimm_b_size), .cls(cls), .pin(pin_pages)
    );

    swz_addr_xform #(.ADDR_W(ADDR_W)) u_xf (
        .in_addr(in_addr), .in_tiled(in_tiled), .in_tile_y(in_tile_y),
        .cls(cls), .out_addr(out_addr)
    );

    swz_page_swap #(.BEAT_W(BEAT_W), .PAGE_BEATS(PAGE_BEATS)) u_swap (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_flip(s_b17_saved ^ s_b17_now), .m_valid(m_valid),
        .m_data(m_data), .m_last(m_last)
    );

    assign swz_class = cls;

    AST_PIN_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pages |-> (swz_class == 2'd0)) else $error("pin with swizzle"); // R6
    AST_DIMM_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_from_dimm |-> !pin_pages) else $error("pin on dimm path"); // R7
    AST_UNTILED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tiled |-> (out_addr == in_addr)) else $error("untiled altered"); // R1
    AST_HIGH_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_addr ^ in_addr) == ((out_addr[6] ^ in_addr[6]) ? ADDR_W'(64) : '0))
        else $error("non-bit-6 altered"); // R1
endmodule

// File: tb/test_bit6_swizzle_unit.sv
module test_bit6_swizzle_unit;
    localparam int ADDR_W = 32, CFG_W = 32, DIMM_W = 8, BEAT_W = 512, PB = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic cfg_remap_en = 0, cfg_from_dimm = 0;
    logic [DIMM_W-1:0] dimm_a_size = '0, dimm_b_size = '0;
    logic [1:0] swz_class;
    logic pin_pages;
    logic [ADDR_W-1:0] in_addr = '0, out_addr;
    logic in_tiled = 0, in_tile_y = 0;
    logic s_valid = 0, s_b17_saved = 0, s_b17_now = 0;
    logic [BEAT_W-1:0] s_data = '0, m_data;
    logic m_valid, m_last;

    int n_chk = 0, n_bad = 0;
    int rx_cnt = 0;
    logic [31:0] rx_tag [0:255];
    logic        rx_last [0:255];

    always #2.5 clk = ~clk;

    bit6_swizzle_unit i_bit6_swizzle_unit (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {pin, class} from the requirements.
    function automatic logic [2:0] ref_mode(logic [CFG_W-1:0] w, logic remap, logic dimm,
                                            logic [DIMM_W-1:0] a, logic [DIMM_W-1:0] b);
        if (dimm) return {1'b0, (a == b) ? 2'd1 : 2'd0};
        if ((&w) || remap || w[1:0] == 2'd3) return 3'b100;
        if (w[1:0] != 2'd2) return 3'b000;
        if (w[2]) return 3'b001;
        return w[3] ? 3'b011 : 3'b010;
    endfunction

    function automatic logic [ADDR_W-1:0] ref_addr(logic [ADDR_W-1:0] a, logic t, logic y, logic [1:0] c);
        logic [ADDR_W-1:0] r = a;
        if (t && c != 0) begin
            r[6] = a[6] ^ a[9] ^ (y ? 1'b0 : a[10]);
            if (c == 2) r[6] ^= a[11];
            if (c == 3) r[6] ^= a[17];
        end
        return r;
    endfunction

    // Output monitor: records tags and last flags.
    always @(negedge clk) begin
        if (rst_n && m_valid && rx_cnt < 256) begin
            rx_tag[rx_cnt]  = m_data[31:0];
            rx_last[rx_cnt] = m_last;
            rx_cnt++;
        end
    end

    task automatic apply_cfg(input logic [CFG_W-1:0] w, input logic remap, input logic dimm,
                             input logic [DIMM_W-1:0] a, input logic [DIMM_W-1:0] b, input string req);
        logic [2:0] e;
        cfg_word = w; cfg_remap_en = remap; cfg_from_dimm = dimm;
        dimm_a_size = a; dimm_b_size = b;
        #1;
        e = ref_mode(w, remap, dimm, a, b);
        check(req, {61'd0, pin_pages, swz_class}, {61'd0, e});
    endtask

    task automatic send_page(input int pg, input logic flip, input bit gaps);
        for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            if (gaps) while ($urandom_range(0, 2) == 0) begin
                s_valid = 0;
                @(negedge clk);
            end
            s_valid = 1;
            s_data = '0;
            s_data[31:0] = (pg << 8) | i;
            if (i == 0) begin s_b17_saved = 1'b0; s_b17_now = flip; end
            else begin s_b17_saved = $urandom_range(0, 1); s_b17_now = $urandom_range(0, 1); end
        end
        @(negedge clk);
        s_valid = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R11 m_valid at reset", {63'd0, m_valid}, 64'd0);
        check("R11 m_last at reset", {63'd0, m_last}, 64'd0);
        rst_n = 1;

        // Directed decode corners.
        apply_cfg('1, 0, 0, 0, 0, "R6 all-ones word");
        apply_cfg(32'h6, 1, 0, 0, 0, "R6 remap enabled");
        apply_cfg(32'h3, 0, 0, 0, 0, "R6 reserved mode");
        apply_cfg(32'h0, 0, 0, 0, 0, "R5 single channel");
        apply_cfg(32'h1, 0, 0, 0, 0, "R5 asymmetric");
        apply_cfg(32'h6, 0, 0, 0, 0, "R5 interleaved xor off");
        apply_cfg(32'h2, 0, 0, 0, 0, "R5 interleaved bit11");
        apply_cfg(32'hA, 0, 0, 0, 0, "R5 interleaved bit17");
        apply_cfg('1, 1, 1, 8'h40, 8'h40, "R7 dimm equal");
        apply_cfg(32'h2, 0, 1, 8'h40, 8'h20, "R7 dimm unequal");

        // Random decode and address vectors.
        for (int v = 0; v < 400; v++) begin
            logic [CFG_W-1:0] w;
            logic [1:0] c;
            w = ($urandom_range(0, 15) == 0) ? '1 : CFG_W'($urandom);
            apply_cfg(w, $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0,
                      DIMM_W'($urandom_range(0, 3)), DIMM_W'($urandom_range(0, 3)), "R5/R6/R7 random");
            c = ref_mode(cfg_word, cfg_remap_en, cfg_from_dimm, dimm_a_size, dimm_b_size) & 3'b011;
            in_addr = $urandom; in_tiled = $urandom_range(0, 3) != 0; in_tile_y = $urandom_range(0, 1);
            #1;
            check(c == 0 || !in_tiled ? "R1 pass" : c == 1 ? "R2 base" : c == 2 ? "R3 bit11" : "R4 bit17",
                  {32'd0, out_addr}, {32'd0, ref_addr(in_addr, in_tiled, in_tile_y, c)});
        end

        // Directed transform: X vs Y base with only bit 10 set.
        apply_cfg(32'h6, 0, 0, 0, 0, "R5 base setup");
        in_addr = 32'h400; in_tiled = 1; in_tile_y = 0; #1;
        check("R2 X uses bit10", {32'd0, out_addr}, 64'h440);
        in_tile_y = 1; #1;
        check("R2 Y ignores bit10", {32'd0, out_addr}, 64'h400);
        apply_cfg(32'hA, 0, 0, 0, 0, "R5 bit17 setup");
        in_addr = 32'h20000; #1;
        check("R4 bit17 flips", {32'd0, out_addr}, 64'h20040);
        apply_cfg(32'h2, 0, 0, 0, 0, "R5 bit11 setup");
        in_addr = 32'h800; #1;
        check("R3 bit11 flips", {32'd0, out_addr}, 64'h840);

        // Timing of first pair, back to back.
        @(negedge clk);
        s_valid = 1; s_data = '0; s_data[31:0] = 32'h900; s_b17_saved = 0; s_b17_now = 1;
        @(negedge clk);
        check("R10 no output after even beat", {63'd0, m_valid}, 64'd0);
        s_data[31:0] = 32'h901;
        @(negedge clk);
        s_valid = 0;
        check("R10 head after odd beat", {32'd0, m_valid ? m_data[31:0] : 32'hdead}, 64'h901);
        @(negedge clk);
        check("R10 tail next cycle", {32'd0, m_valid ? m_data[31:0] : 32'hdead}, 64'h900);
        // Finish that page with remaining 62 beats.
        for (int i = 2; i < PB; i++) begin
            s_valid = 1; s_data[31:0] = 32'h900 | i;
            @(negedge clk);
        end
        s_valid = 0;
        repeat (4) @(negedge clk);
        rx_cnt = 0;

        // Streams: swap, straight, swap with gaps.
        send_page(1, 1'b1, 1'b0);
        send_page(2, 1'b0, 1'b1);
        send_page(3, 1'b1, 1'b1);
        repeat (6) @(negedge clk);
        check("R8/R9 beat count", rx_cnt, 3 * PB);
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < PB; k++) begin
                int src;
                src = (p == 1) ? k : (k ^ 1);
                check(p == 1 ? "R9 in-order beat" : "R8 swapped beat",
                      {32'd0, rx_tag[p*PB+k]}, {32'd0, 32'((p + 1) << 8 | src)});
                check("R10 last flag", {63'd0, rx_last[p*PB+k]}, {63'd0, k == PB - 1});
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule